// File: doc/BRIEF.md
# Saturating Byte-by-Halfword SIMD Multiplier

This execution unit carries out one packed-SIMD multiply. The unit treats the low 32-bit word of the first operand as four unsigned bytes and uses only the upper two of them. It multiplies each of those bytes by the matching unsigned halfword of the second operand's low word. Each 24-bit product is clamped to 16 bits. The upper byte's result goes to the high half of a 32-bit pair, and that pair is sign-extended from bit 31 to fill a 64-bit destination.

The unit also decodes the 32-bit instruction word. It accepts either a standard or a compact encoding, and the `enc_sel` input picks which one. The unit reports the destination, source-s and source-t register indices alongside the result. When the unit is disabled, or when the word does not match the selected encoding, it signals a trap and writes no result.

A sticky saturation flag sits in a control register. A pulse also marks accumulator 0 as clobbered each time a result is written. The pipeline has two register stages, so every accepted input leaves exactly two cycles later. One input can be accepted on every cycle.

Top module: `smul_bh_unit`

## Requirements
- R1: Lane B multiplies `opnd_s[31:24]` by `opnd_t[31:16]`, and lane A multiplies `opnd_s[23:16]` by `opnd_t[15:0]`, both unsigned. When a product fits in 16 bits, that lane's result is the product itself. All other operand bits have no effect on the result.
- R2: A lane whose 24-bit product has any bit set above bit 15 yields 0xFFFF. A product of exactly 0xFFFF passes through unchanged, and 0x10000 saturates.
- R3: `out_dest[31:16]` holds lane B and `out_dest[15:0]` holds lane A. Bits 63..32 all equal bit 31.
- R4: A result in which either lane saturated sets `ctl_reg[21]` in the same cycle as its `out_valid`. The bit then stays set until reset. No other bit of `ctl_reg` ever becomes 1.
- R5: With `enc_sel`=0, the unit accepts a word whose fields from bit 31 down are: major 011111 (6 bits), rs (5), rt (5), rd (5), sub-op 00110 (5), function 010000 (6). It outputs rd, rs and rt on `out_rd`, `out_rs` and `out_rt`.
- R6: With `enc_sel`=1, the unit accepts a word whose fields from bit 31 down are: major 000000 (6 bits), rt (5), rs (5), rd (5), a 0 bit, minor 0010010101 (10). Note that rt comes before rs.
- R7: An accepted input with `unit_en`=0, or with a word that does not match the selected encoding, gives `out_trap`=1 with `out_valid`=0. It leaves `ctl_reg` unchanged even when the operands would saturate.
- R8: Each input presented with `in_valid` at a rising edge appears on `out_valid` or `out_trap` two edges later, in order. Inputs may be presented back-to-back, and no output appears without a matching input.
- R9: `acc0_clobber` is 1 exactly in the cycles where `out_valid` is 1, and 0 on traps.
- R10: While `rst_n` is low at a rising edge, the unit clears `out_valid`, `out_trap` and `ctl_reg`.
- R11: A word that is valid only in the encoding not chosen by `enc_sel` traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operands and word are present |
| unit_en | input | 1 | Unit enabled; 0 turns every input into a trap |
| enc_sel | input | 1 | 0: standard encoding, 1: compact encoding |
| instr | input | 32 | Instruction word |
| opnd_s | input | 64 | First operand (byte vector) |
| opnd_t | input | 64 | Second operand (halfword vector) |
| out_valid | output | 1 | Result write pulse |
| out_trap | output | 1 | Trap pulse (disabled or undecodable word) |
| out_dest | output | 64 | Packed, sign-extended result |
| out_rd | output | 5 | Decoded destination index |
| out_rs | output | 5 | Decoded source-s index |
| out_rt | output | 5 | Decoded source-t index |
| acc0_clobber | output | 1 | Accumulator 0 is now undefined |
| ctl_reg | output | 32 | Control register holding the sticky saturation flag at bit 21 |

## Verification
Some properties are checked on every cycle. The first is the two-cycle delay between an input and its result or trap. The checks also cover that a result and a trap never occur together, and the sign extension of bit 31. On the flag, they cover that it is sticky, that it can rise only alongside a result and never on a trap, and that no other control bit ever rises. They also cover the cleared state after reset. The values themselves can only be shown by the bench's scenarios: the lane products, saturation exactly at 0x10000 but not at 0xFFFF, the field order of each encoding and the trap on a word for the wrong encoding. The bench compares these against its own reference model.

// File: rtl/smul_pkg.sv
// Shared constants and types for the saturating byte-by-halfword multiplier.
// Assumes a 32-bit instruction word and 5-bit register indices.
package smul_pkg;
    localparam int INSTR_W = 32;
    localparam int RD_W    = 5;

    // Standard encoding field values
    localparam logic [5:0] STD_MAJOR = 6'b011111;
    localparam logic [4:0] STD_SUB   = 5'b00110;
    localparam logic [5:0] STD_FUNC  = 6'b010000;

    // Compact encoding field values
    localparam logic [5:0] CMP_MAJOR = 6'b000000;
    localparam logic [9:0] CMP_MINOR = 10'b0010010101;

    typedef enum logic {
        ENC_STD = 1'b0,
        ENC_CMP = 1'b1
    } enc_e;

    typedef struct packed {
        logic            match;
        logic [RD_W-1:0] rd;
        logic [RD_W-1:0] rs;
        logic [RD_W-1:0] rt;
    } dec_t;
endpackage

// File: rtl/smul_decode.sv
// Instruction decoder. Matches the word against the encoding picked by
// enc_sel and extracts the register indices. Purely combinational.
// Assumes the caller qualifies the match with its own valid and enable.
module smul_decode
    import smul_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               enc_sel,
    output dec_t               dec
);
    dec_t std_d;
    dec_t cmp_d;

    // Standard layout: major, rs, rt, rd, sub-op, function
    always_comb begin
        std_d.match = (instr[31:26] == STD_MAJOR) &&
                      (instr[10:6]  == STD_SUB)   &&
                      (instr[5:0]   == STD_FUNC);
        std_d.rs    = instr[25:21];
        std_d.rt    = instr[20:16];
        std_d.rd    = instr[15:11];
    end

    // Compact layout: major, rt, rs, rd, zero bit, minor
    always_comb begin
        cmp_d.match = (instr[31:26] == CMP_MAJOR) &&
                      (instr[10]    == 1'b0)      &&
                      (instr[9:0]   == CMP_MINOR);
        cmp_d.rt    = instr[25:21];
        cmp_d.rs    = instr[20:16];
        cmp_d.rd    = instr[15:11];
    end

    // Select the decode of the chosen encoding
    always_comb begin
        dec = (enc_e'(enc_sel) == ENC_CMP) ? cmp_d : std_d;
    end
endmodule

// File: rtl/smul_lane_mul.sv
// One lane's unsigned multiplier: an A_W-bit by B_W-bit full-width product.
// Combinational; the caller registers the result.
module smul_lane_mul #(
    parameter int A_W = 8,
    parameter int B_W = 16,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);
    // Zero-extend both factors and multiply at full width
    always_comb begin
        p = P_W'(a) * P_W'(b);
    end
endmodule

// File: rtl/smul_sat_pack.sv
// Clamps each lane's product to HALF_W bits, packs the lanes with lane 0
// lowest, and sign-extends the packed word to XLEN. Reports whether any
// lane was clamped. Combinational.
module smul_sat_pack #(
    parameter int LANES  = 2,
    parameter int HALF_W = 16,
    parameter int PROD_W = 24,
    parameter int XLEN   = 64,
    localparam int PACK_W = LANES * HALF_W
) (
    input  logic [LANES-1:0][PROD_W-1:0] prod,
    output logic [XLEN-1:0]              dest,
    output logic                         sat_any
);
    logic [PACK_W-1:0] packed_w;
    logic [LANES-1:0]  sat_vec;

    for (genvar i = 0; i < LANES; i++) begin : g_sat
        // Clamp one lane when any bit above the result width is set
        always_comb begin
            sat_vec[i] = |prod[i][PROD_W-1:HALF_W];
            packed_w[i*HALF_W +: HALF_W] = sat_vec[i] ? {HALF_W{1'b1}}
                                                      : prod[i][HALF_W-1:0];
        end
    end

    // Sign-extend the packed word and merge the saturation indications
    always_comb begin
        dest    = {{(XLEN-PACK_W){packed_w[PACK_W-1]}}, packed_w};
        sat_any = |sat_vec;
    end
endmodule

// File: rtl/smul_bh_unit.sv
// Two-stage saturating byte-by-halfword SIMD multiply unit.
// Stage 1 decodes the word and registers the raw lane products.
// Stage 2 registers the clamped, packed result and updates the sticky flag.
// Assumes operands are stable while in_valid is high at a rising edge.
module smul_bh_unit
    import smul_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int WORD_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int HALF_W   = 16,
    parameter int LANES    = 2,
    parameter int CTL_W    = 32,
    parameter int FLAG_BIT = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               unit_en,
    input  logic               enc_sel,
    input  logic [INSTR_W-1:0] instr,
    input  logic [XLEN-1:0]    opnd_s,
    input  logic [XLEN-1:0]    opnd_t,
    output logic               out_valid,
    output logic               out_trap,
    output logic [XLEN-1:0]    out_dest,
    output logic [RD_W-1:0]    out_rd,
    output logic [RD_W-1:0]    out_rs,
    output logic [RD_W-1:0]    out_rt,
    output logic               acc0_clobber,
    output logic [CTL_W-1:0]   ctl_reg
);
    localparam int PROD_W = BYTE_W + HALF_W;
    localparam int S_BASE = WORD_W - LANES * BYTE_W;
    localparam int T_TOP  = LANES * HALF_W;

    dec_t                          dec;
    logic [LANES-1:0][PROD_W-1:0]  prod_c;
    logic [LANES-1:0][PROD_W-1:0]  prod_q;
    logic                          v1_q, t1_q;
    logic [RD_W-1:0]               rd1_q, rs1_q, rt1_q;
    logic [XLEN-1:0]               pack_c;
    logic                          sat_c;
    logic                          v2_q, t2_q;
    logic [XLEN-1:0]               dest_q;
    logic [RD_W-1:0]               rd2_q, rs2_q, rt2_q;
    logic [CTL_W-1:0]              ctl_q;
    logic                          unused_bits;

    assign unused_bits = ^{opnd_s[XLEN-1:WORD_W], opnd_s[S_BASE-1:0],
                           opnd_t[XLEN-1:T_TOP]};

    smul_decode u_dec (
        .instr   (instr),
        .enc_sel (enc_sel),
        .dec     (dec)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        smul_lane_mul #(
            .A_W (BYTE_W),
            .B_W (HALF_W)
        ) u_mul (
            .a (opnd_s[S_BASE + i*BYTE_W +: BYTE_W]),
            .b (opnd_t[i*HALF_W +: HALF_W]),
            .p (prod_c[i])
        );
    end

    // Stage 1 control: split accepted inputs into results and traps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            t1_q <= 1'b0;
        end else begin
            v1_q <= in_valid &&  (unit_en && dec.match);
            t1_q <= in_valid && !(unit_en && dec.match);
        end
    end

    // Stage 1 data: capture products and indices of each accepted input
    always_ff @(posedge clk) begin
        if (in_valid) begin
            prod_q <= prod_c;
            rd1_q  <= dec.rd;
            rs1_q  <= dec.rs;
            rt1_q  <= dec.rt;
        end
    end

    smul_sat_pack #(
        .LANES  (LANES),
        .HALF_W (HALF_W),
        .PROD_W (PROD_W),
        .XLEN   (XLEN)
    ) u_pack (
        .prod    (prod_q),
        .dest    (pack_c),
        .sat_any (sat_c)
    );

    // Stage 2 control: output pulses and sticky saturation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q  <= 1'b0;
            t2_q  <= 1'b0;
            ctl_q <= '0;
        end else begin
            v2_q <= v1_q;
            t2_q <= t1_q;
            if (v1_q && sat_c) begin
                ctl_q[FLAG_BIT] <= 1'b1;
            end
        end
    end

    // Stage 2 data: hold the latest result and its register indices
    always_ff @(posedge clk) begin
        if (v1_q) begin
            dest_q <= pack_c;
            rd2_q  <= rd1_q;
            rs2_q  <= rs1_q;
            rt2_q  <= rt1_q;
        end
    end

    assign out_valid    = v2_q;
    assign out_trap     = t2_q;
    assign out_dest     = dest_q;
    assign out_rd       = rd2_q;
    assign out_rs       = rs2_q;
    assign out_rt       = rt2_q;
    assign acc0_clobber = v2_q;
    assign ctl_reg      = ctl_q;
endmodule

// File: rtl/smul_bh_unit_chk.sv
// Property checker for smul_bh_unit, attached by bind. It observes ports
// only and keeps its own record of accepted inputs to time the outputs.
module smul_bh_unit_chk #(
    parameter int XLEN     = 64,
    parameter int CTL_W    = 32,
    parameter int FLAG_BIT = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_trap,
    input logic [XLEN-1:0]  out_dest,
    input logic [CTL_W-1:0] ctl_reg
);
    localparam logic [CTL_W-1:0] FLAG_MASK = CTL_W'(1) << FLAG_BIT;

    logic seen1_q, seen2_q;
    logic prev_rst_low = 1'b0;

    // Delay line of accepted inputs, independent of the design's pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1_q <= 1'b0;
            seen2_q <= 1'b0;
        end else begin
            seen1_q <= in_valid;
            seen2_q <= seen1_q;
        end
    end

    // Remember whether reset was applied at the previous edge
    always_ff @(posedge clk) begin
        prev_rst_low <= !rst_n;
    end

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_trap) == seen2_q); // R8
    AST_RESULT_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_trap)); // R7
    AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dest[XLEN-1:32] == {(XLEN-32){out_dest[31]}})); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_reg[FLAG_BIT]) |-> ctl_reg[FLAG_BIT]); // R4
    AST_FLAG_RISES_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_reg[FLAG_BIT]) |-> out_valid); // R4
    AST_OTHER_CTL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_reg & ~FLAG_MASK) == '0); // R4
    AST_TRAP_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> $stable(ctl_reg)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        prev_rst_low |-> (ctl_reg == '0 && !out_valid && !out_trap)); // R10
endmodule

bind smul_bh_unit smul_bh_unit_chk #(
    .XLEN     (XLEN),
    .CTL_W    (CTL_W),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_trap  (out_trap),
    .out_dest  (out_dest),
    .ctl_reg   (ctl_reg)
);

// File: tb/smul_bh_unit_test.sv
// Scoreboard bench: the driver pushes reference results into a queue and
// the monitor pops and compares them as the unit produces outputs.
`timescale 1ns/1ps
module smul_bh_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        unit_en = 1'b0;
    logic        enc_sel = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opnd_s = '0;
    logic [63:0] opnd_t = '0;
    logic        out_valid, out_trap, acc0_clobber;
    logic [63:0] out_dest;
    logic [4:0]  out_rd, out_rs, out_rt;
    logic [31:0] ctl_reg;

    always #2 clk = ~clk;

    smul_bh_unit uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .unit_en (unit_en),
        .enc_sel (enc_sel), .instr (instr), .opnd_s (opnd_s), .opnd_t (opnd_t),
        .out_valid (out_valid), .out_trap (out_trap), .out_dest (out_dest),
        .out_rd (out_rd), .out_rs (out_rs), .out_rt (out_rt),
        .acc0_clobber (acc0_clobber), .ctl_reg (ctl_reg)
    );

    typedef struct {
        logic        trap;
        logic [63:0] dest;
        logic [4:0]  rd, rs, rt;
        logic [31:0] ctl;
        int          cyc;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    logic model_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] lane_ref(input logic [7:0] a, input logic [15:0] b);
        logic [23:0] p;
        p = 24'(a) * 24'(b);
        return (p[23:16] != 8'h00) ? {1'b1, 16'hFFFF} : {1'b0, p[15:0]};
    endfunction

    function automatic logic [31:0] std_word(input logic [4:0] rs, rt, rd);
        return {6'b011111, rs, rt, rd, 5'b00110, 6'b010000};
    endfunction

    function automatic logic [31:0] cmp_word(input logic [4:0] rs, rt, rd);
        return {6'b000000, rt, rs, rd, 1'b0, 10'b0010010101};
    endfunction

    // Driver: present one input and push its reference outcome
    task automatic drive(input logic en, input logic enc, input logic [31:0] w,
                         input logic [63:0] s, input logic [63:0] t,
                         input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt,
                         input logic exp_trap, input string req);
        exp_t        e;
        logic [16:0] lb, la;
        @(negedge clk);
        in_valid = 1'b1; unit_en = en; enc_sel = enc; instr = w;
        opnd_s = s; opnd_t = t;
        lb = lane_ref(s[31:24], t[31:16]);
        la = lane_ref(s[23:16], t[15:0]);
        e.trap = exp_trap;
        e.dest = {{32{lb[15]}}, lb[15:0], la[15:0]};
        if (!exp_trap && (lb[16] || la[16])) model_flag = 1'b1;
        e.rd = rd; e.rs = rs; e.rt = rt;
        e.ctl = 32'(model_flag) << 21;
        e.cyc = cyc;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare every output pulse against the oldest expectation
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_trap)) begin
            if (q.size() == 0) begin
                check(1'b0, "R8 unexpected output", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc - e.cyc == 2, "R8 latency", 64'(cyc - e.cyc), 64'd2);
                check(out_trap == e.trap, {e.req, " trap"}, 64'(out_trap), 64'(e.trap));
                check(out_valid == !e.trap, {e.req, " R7 valid"}, 64'(out_valid), 64'(!e.trap));
                check(acc0_clobber == !e.trap, "R9 clobber", 64'(acc0_clobber), 64'(!e.trap));
                check(ctl_reg == e.ctl, {e.req, " R4 ctl"}, 64'(ctl_reg), 64'(e.ctl));
                if (!e.trap) begin
                    check(out_dest == e.dest, {e.req, " dest"}, out_dest, e.dest);
                    check(out_rd == e.rd, {e.req, " rd"}, 64'(out_rd), 64'(e.rd));
                    check(out_rs == e.rs, {e.req, " rs"}, 64'(out_rs), 64'(e.rs));
                    check(out_rt == e.rt, {e.req, " rt"}, 64'(out_rt), 64'(e.rt));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!out_valid && !out_trap, "R10 reset pulses", 64'(out_valid | out_trap), 64'd0);
        check(ctl_reg == 32'd0, "R10 reset ctl", 64'(ctl_reg), 64'd0);
        rst_n = 1'b1;
        idle(1);

        // R1: zero operands, plain products, unused operand bits ignored
        drive(1, 0, std_word(5'd1, 5'd2, 5'd3), 64'd0, 64'd0, 5'd3, 5'd1, 5'd2, 0, "R1 zero");
        drive(1, 0, std_word(5'd4, 5'd5, 5'd6), 64'hDEADBEEF_1234_A5A5,
              64'hCAFEF00D_0100_0003, 5'd6, 5'd4, 5'd5, 0, "R1 plain");
        // R2: 0x01*0xFFFF and 0xFF*0x0101 both equal 0xFFFF, no saturation
        drive(1, 0, std_word(5'd7, 5'd8, 5'd9), 64'h0000_0000_01FF_0000,
              64'h0000_0000_FFFF_0101, 5'd9, 5'd7, 5'd8, 0, "R2 edge 0xFFFF");
        // R3: lane B 0x01*0x8000 sets bit 31, upper word all ones
        drive(1, 0, std_word(5'd10, 5'd11, 5'd12), 64'h0000_0000_0102_0000,
              64'h0000_0000_8000_0010, 5'd12, 5'd10, 5'd11, 0, "R3 sign");
        // R6: compact encoding with rt ahead of rs
        drive(1, 1, cmp_word(5'd13, 5'd14, 5'd15), 64'h0000_0000_0304_0000,
              64'h0000_0000_0011_0022, 5'd15, 5'd13, 5'd14, 0, "R6 compact");
        // R5: standard encoding index positions
        drive(1, 0, std_word(5'd31, 5'd0, 5'd17), 64'h0000_0000_0506_0000,
              64'h0000_0000_0007_0008, 5'd17, 5'd31, 5'd0, 0, "R5 standard");
        // R7: disabled unit with saturating operands traps, flag unchanged
        drive(0, 0, std_word(5'd1, 5'd1, 5'd1), 64'h0000_0000_FFFF_0000,
              64'h0000_0000_FFFF_FFFF, 5'd1, 5'd1, 5'd1, 1, "R7 disabled");
        // R7: corrupted function field traps
        drive(1, 0, std_word(5'd1, 5'd1, 5'd1) ^ 32'h1, 64'h0000_0000_FFFF_0000,
              64'h0000_0000_FFFF_FFFF, 5'd1, 5'd1, 5'd1, 1, "R7 mismatch");
        // R11: valid standard word while compact encoding is selected
        drive(1, 1, std_word(5'd2, 5'd3, 5'd4), 64'h0000_0000_FFFF_0000,
              64'h0000_0000_FFFF_FFFF, 5'd4, 5'd2, 5'd3, 1, "R11 wrong encoding");
        idle(4);
        check(ctl_reg == 32'd0, "R7 flag clear after traps", 64'(ctl_reg), 64'd0);

        // R2: lane A 0x80*0x0200 = 0x10000 saturates and sets the flag (R4)
        drive(1, 0, std_word(5'd2, 5'd3, 5'd20), 64'h0000_0000_0280_0000,
              64'h0000_0000_0004_0200, 5'd20, 5'd2, 5'd3, 0, "R2 edge 0x10000");
        // R2: 0xFF*0xFFFF in both lanes
        drive(1, 1, cmp_word(5'd5, 5'd6, 5'd21), 64'h0000_0000_FFFF_0000,
              64'h0000_0000_FFFF_FFFF, 5'd21, 5'd5, 5'd6, 0, "R2 max");
        // R4: flag stays set after a non-saturating result
        drive(1, 0, std_word(5'd8, 5'd9, 5'd22), 64'h0000_0000_0101_0000,
              64'h0000_0000_0001_0001, 5'd22, 5'd8, 5'd9, 0, "R4 sticky");
        // R8: back-to-back mixed burst
        for (int k = 0; k < 8; k++) begin
            logic [63:0] s, t;
            s = {32'h0, 8'(k * 37 + 1), 8'(k * 91 + 7), 16'h0};
            t = {32'h0, 16'(k * 4099 + 3), 16'(k * 777)};
            if (k % 3 == 2)
                drive(1, 0, std_word(5'(k), 5'(k + 1), 5'(k + 2)) ^ 32'h40, s, t,
                      5'(k + 2), 5'(k), 5'(k + 1), 1, "R8 burst trap");
            else
                drive(1, k[0], (k % 2 == 1) ? cmp_word(5'(k), 5'(k + 1), 5'(k + 2))
                                            : std_word(5'(k), 5'(k + 1), 5'(k + 2)),
                      s, t, 5'(k + 2), 5'(k), 5'(k + 1), 0, "R8 burst");
        end
        idle(5);
        check(q.size() == 0, "R8 all drained", 64'(q.size()), 64'd0);

        // R10: reset mid-run clears the sticky flag
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(ctl_reg == 32'd0, "R10 mid-run reset ctl", 64'(ctl_reg), 64'd0);
        check(!out_valid && !out_trap, "R10 mid-run reset pulses",
              64'(out_valid | out_trap), 64'd0);
        rst_n = 1'b1;
        model_flag = 1'b0;
        drive(1, 0, std_word(5'd1, 5'd2, 5'd3), 64'h0000_0000_0203_0000,
              64'h0000_0000_0005_0006, 5'd3, 5'd1, 5'd2, 0, "R10 after reset");
        idle(5);
        check(q.size() == 0, "R8 final drain", 64'(q.size()), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule